// File: doc/BRIEF.md
# Banked Absolute Effective Address Generator

This block turns an absolute-family operand into a 24-bit address for a 16-bit processor that keeps its bank bytes in separate registers. It handles four modes. Plain absolute places the 16-bit operand under the data bank byte. The two indexed modes add X or Y to that address, and a carry out of the low 16 bits ripples into the bank byte. The indexed-indirect jump mode adds X to the operand to form a pointer in bank zero. It then reads two bytes through a simple byte read port and returns them as a new program counter, with the program bank byte kept as it was at the start of the operation.

A one-cycle `start` pulse launches an operation while the block is idle. The three direct modes finish one cycle later. The jump mode holds `busy` high while it runs its two read handshakes, then pulses `done`. The controller has four states:

- `ST_IDLE` waits for `start`. It moves to `ST_DONE` for a direct mode and to `ST_FETCH_LO` for the jump mode.
- `ST_FETCH_LO` requests the pointer byte. It moves to `ST_FETCH_HI` when the read returns.
- `ST_FETCH_HI` requests the byte after it. It moves to `ST_DONE` when the read returns.
- `ST_DONE` presents the result for one cycle and then returns to `ST_IDLE`.

Top module: `eff_addr_gen`

## Requirements
- R1: With mode code 0 (absolute), `result` equals {data bank, operand}, `is_jump` is 0, and `done` is high in the cycle after the `start` edge.
- R2: With mode code 1 (indexed by X), `result` equals ({data bank, operand} + X) modulo 2^24, so a carry out of bit 15 increments the bank byte.
- R3: With mode code 2 (indexed by Y), `result` equals ({data bank, operand} + Y) modulo 2^24, including carry into the bank byte.
- R4: When `idx8` is 1, only bits 7:0 of the selected index are added, zero-extended. This holds for modes 1, 2 and 3.
- R5: With mode code 3 (indexed indirect jump), the first read request carries address {8'h00, (operand + X) mod 2^16}. `rd_req` and `rd_addr` hold steady until `rd_valid` is seen.
- R6: The second read request of the jump uses {8'h00, (pointer + 1) mod 2^16}, so the pointer wraps inside bank zero.
- R7: When a jump finishes, `result` is {program bank sampled at start, second byte, first byte} and `is_jump` is 1. `done` is high in the cycle after the edge that accepts the second read.
- R8: `busy` is high from the cycle after a jump start until the second read is accepted. `done` is a single-cycle pulse, and `busy` and `done` are never high together.
- R9: A `start` that arrives while the block is not idle is ignored, and `result` changes only when an operation is accepted or finishes.
- R10: After reset, `busy`, `done`, `rd_req`, `is_jump` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse, accepted only while idle |
| mode | input | 2 | 0 absolute, 1 indexed X, 2 indexed Y, 3 indexed indirect jump |
| operand | input | 16 | Operand; instruction byte two is the low byte, byte three the high byte |
| x_idx | input | 16 | X index register |
| y_idx | input | 16 | Y index register |
| data_bank | input | 8 | Data bank byte |
| prog_bank | input | 8 | Program bank byte |
| idx8 | input | 1 | 1 selects 8-bit index width |
| busy | output | 1 | Jump pointer fetch in progress |
| done | output | 1 | One-cycle completion strobe |
| is_jump | output | 1 | Result is a jump target |
| result | output | 24 | Effective address, or {bank, new PC} for the jump |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 24 | Byte read address |
| rd_valid | input | 1 | Read data valid; accepts the pending request |
| rd_data | input | 8 | Read data byte |

## Verification
Random mixes of operand, X, Y and bank bytes are run in every mode. The bank byte is checked separately from the low 16 bits, so a carry into the bank is not confused with a 16-bit wrap. Directed cases probe three edges:

- an operand and index sum just past FFFFh, with a bank of 12h and with FFh;
- a large X under `idx8`, which separates the zero-extended low byte from the full register;
- a jump pointer at FFFFh, which separates a wrap inside bank zero from a carry into bank one.

Jump reads return after random wait states, which shows that the request is held. A `start` is injected while the block is busy, which shows it is ignored.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [1:0] {
        MODE_ABS  = 2'd0,
        MODE_ABSX = 2'd1,
        MODE_ABSY = 2'd2,
        MODE_JIND = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_LO = 2'd1,
        ST_FETCH_HI = 2'd2,
        ST_DONE     = 2'd3
    } state_e;
endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
    parameter int WORD_W = 16,
    parameter int BANK_W = 8,
    localparam int ADDR_W = WORD_W + BANK_W,
    localparam int BYTE_W = WORD_W / 2
) (
    input  eag_pkg::mode_e      mode,
    input  logic [WORD_W-1:0]   operand,
    input  logic [WORD_W-1:0]   x_idx,
    input  logic [WORD_W-1:0]   y_idx,
    input  logic [BANK_W-1:0]   data_bank,
    input  logic                idx8,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic [WORD_W-1:0]   ptr
);
    import eag_pkg::*;

    logic [WORD_W-1:0] idx_sel;
    logic [WORD_W-1:0] idx_eff;

    always_comb begin
        idx_sel = (mode == MODE_ABSY) ? y_idx : x_idx;
        idx_eff = idx8 ? {{(WORD_W-BYTE_W){1'b0}}, idx_sel[BYTE_W-1:0]} : idx_sel;
        if (mode == MODE_ABS)
            eff_addr = {data_bank, operand};
        else
            eff_addr = {data_bank, operand} + {{BANK_W{1'b0}}, idx_eff};
        ptr = operand + idx_eff;
    end
endmodule

// File: rtl/eag_fetch_fsm.sv
module eag_fetch_fsm #(
    parameter int WORD_W = 16,
    parameter int BANK_W = 8,
    localparam int ADDR_W = WORD_W + BANK_W,
    localparam int BYTE_W = WORD_W / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  eag_pkg::mode_e      mode,
    input  logic [WORD_W-1:0]   ptr,
    input  logic                rd_valid,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic                accept,
    output logic                pc_load,
    output logic [WORD_W-1:0]   pc_val,
    output logic                busy,
    output logic                done,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr
);
    import eag_pkg::*;

    state_e            state, state_nx;
    logic [WORD_W-1:0] ptr_q;
    logic [BYTE_W-1:0] lo_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = (mode == MODE_JIND) ? ST_FETCH_LO : ST_DONE;
            ST_FETCH_LO: if (rd_valid) state_nx = ST_FETCH_HI;
            ST_FETCH_HI: if (rd_valid) state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr_q <= '0;
            lo_q  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start)
                ptr_q <= ptr;
            if (state == ST_FETCH_LO && rd_valid)
                lo_q <= rd_data;
        end
    end

    always_comb begin
        accept  = 1'b0;
        pc_load = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        rd_req  = 1'b0;
        rd_addr = '0;
        pc_val  = {rd_data, lo_q};
        unique case (state)
            ST_IDLE:     accept = start;
            ST_FETCH_LO: begin
                busy    = 1'b1;
                rd_req  = 1'b1;
                rd_addr = {{BANK_W{1'b0}}, ptr_q};
            end
            ST_FETCH_HI: begin
                busy    = 1'b1;
                rd_req  = 1'b1;
                rd_addr = {{BANK_W{1'b0}}, ptr_q + {{(WORD_W-1){1'b0}}, 1'b1}};
                pc_load = rd_valid;
            end
            ST_DONE:     done = 1'b1;
        endcase
    end

    AST_REQ_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_addr[ADDR_W-1:WORD_W] == '0); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R5
    AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && !pc_load) |=> (rd_req && rd_addr[WORD_W-1:0] == $past(rd_addr[WORD_W-1:0]) + 1'b1)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8
    AST_DONE_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> done); // R7
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
    parameter int WORD_W = 16,
    parameter int BANK_W = 8,
    localparam int ADDR_W = WORD_W + BANK_W,
    localparam int BYTE_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] x_idx,
    input  logic [WORD_W-1:0] y_idx,
    input  logic [BANK_W-1:0] data_bank,
    input  logic [BANK_W-1:0] prog_bank,
    input  logic              idx8,
    output logic              busy,
    output logic              done,
    output logic              is_jump,
    output logic [ADDR_W-1:0] result,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_data
);
    import eag_pkg::*;

    mode_e             mode_i;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] ptr;
    logic              accept;
    logic              pc_load;
    logic [WORD_W-1:0] pc_val;
    logic [BANK_W-1:0] bank_q;

    assign mode_i = mode_e'(mode);

    eag_index_add #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_add (
        .mode      (mode_i),
        .operand   (operand),
        .x_idx     (x_idx),
        .y_idx     (y_idx),
        .data_bank (data_bank),
        .idx8      (idx8),
        .eff_addr  (eff_addr),
        .ptr       (ptr)
    );

    eag_fetch_fsm #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode_i),
        .ptr      (ptr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .accept   (accept),
        .pc_load  (pc_load),
        .pc_val   (pc_val),
        .busy     (busy),
        .done     (done),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            is_jump <= 1'b0;
            bank_q  <= '0;
        end else if (accept) begin
            is_jump <= (mode_i == MODE_JIND);
            if (mode_i == MODE_JIND)
                bank_q <= prog_bank;
            else
                result <= eff_addr;
        end else if (pc_load) begin
            result <= {bank_q, pc_val};
        end
    end

    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !pc_load) |=> $stable(result)); // R9
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept); // R9
endmodule

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] operand = '0;
    logic [15:0] x_idx = '0;
    logic [15:0] y_idx = '0;
    logic [7:0]  data_bank = '0;
    logic [7:0]  prog_bank = '0;
    logic        idx8 = 1'b0;
    logic        busy, done, is_jump, rd_req;
    logic [23:0] result, rd_addr;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    eff_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .operand(operand),
        .x_idx(x_idx), .y_idx(y_idx), .data_bank(data_bank), .prog_bank(prog_bank),
        .idx8(idx8), .busy(busy), .done(done), .is_jump(is_jump), .result(result),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [15:0] eff_idx(input logic [15:0] v, input logic i8);
        return i8 ? {8'h00, v[7:0]} : v;
    endfunction

    function automatic logic [23:0] exp_direct(input logic [1:0] m, input logic [15:0] op,
            input logic [15:0] x, input logic [15:0] y, input logic [7:0] db, input logic i8);
        logic [15:0] ix;
        ix = (m == 2'd2) ? eff_idx(y, i8) : eff_idx(x, i8);
        if (m == 2'd0) return {db, op};
        return {db, op} + {8'h00, ix};
    endfunction

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3c;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] m, input logic [15:0] op, input logic [15:0] x,
            input logic [15:0] y, input logic [7:0] db, input logic [7:0] pb, input logic i8);
        mode = m; operand = op; x_idx = x; y_idx = y; data_bank = db; prog_bank = pb; idx8 = i8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_direct(input logic [1:0] m, input logic [15:0] op, input logic [15:0] x,
            input logic [15:0] y, input logic [7:0] db, input logic i8, input string tag);
        logic [23:0] e;
        e = exp_direct(m, op, x, y, db, i8);
        launch(m, op, x, y, db, 8'h55, i8);
        chk(done == 1'b1 && busy == 1'b0, {tag, " done"}, {22'd0, busy, done}, 24'd1);
        chk(result == e, {tag, " result"}, result, e);
        chk(is_jump == 1'b0, {tag, " is_jump"}, {23'd0, is_jump}, 24'd0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done pulse", {23'd0, done}, 24'd0);
    endtask

    task automatic serve(input int lat, input logic [23:0] exp_addr, input string tag, input logic inject);
        for (int i = 0; i < lat; i++) begin
            chk(rd_req == 1'b1 && busy == 1'b1, {tag, " req held"}, {22'd0, rd_req, busy}, 24'd3);
            chk(rd_addr == exp_addr, {tag, " addr held"}, rd_addr, exp_addr);
            if (inject && i == 0) begin
                mode = 2'd0; operand = 16'hdead; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(rd_req == 1'b1 && rd_addr == exp_addr, {tag, " addr"}, rd_addr, exp_addr);
        rd_valid = 1'b1;
        rd_data = mem_byte(rd_addr[15:0]);
        @(negedge clk);
        rd_valid = 1'b0;
        rd_data = 8'hxx;
    endtask

    task automatic do_jump(input logic [15:0] op, input logic [15:0] x, input logic [7:0] pb,
            input logic i8, input int l1, input int l2, input logic inject);
        logic [15:0] p, p1;
        logic [23:0] e;
        p  = op + eff_idx(x, i8);
        p1 = p + 16'd1;
        e  = {pb, mem_byte(p1), mem_byte(p)};
        launch(2'd3, op, x, 16'h7777, 8'h99, pb, i8);
        chk(busy == 1'b1 && done == 1'b0, "R8 busy after jump start", {22'd0, busy, done}, 24'd2);
        serve(l1, {8'h00, p}, "R5", inject);
        serve(l2, {8'h00, p1}, "R6", 1'b0);
        prog_bank = ~pb;
        chk(done == 1'b1 && busy == 1'b0, "R7 done after second read", {22'd0, busy, done}, 24'd1);
        chk(result == e, inject ? "R9 jump result after ignored start" : "R7 jump result", result, e);
        chk(is_jump == 1'b1, "R7 is_jump", {23'd0, is_jump}, 24'd1);
        @(negedge clk);
        chk(done == 1'b0 && rd_req == 1'b0, "R8 done pulse", {22'd0, done, rd_req}, 24'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0c0ffee5));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && rd_req == 0 && is_jump == 0 && result == 0,
            "R10 reset state", result, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_direct(2'd0, 16'h3412, 16'h1111, 16'h2222, 8'h7e, 1'b0, "R1 absolute");
        do_direct(2'd1, 16'hfff0, 16'h0020, 16'h0000, 8'h12, 1'b0, "R2 carry into bank");
        do_direct(2'd1, 16'hffff, 16'h0001, 16'h0000, 8'hff, 1'b0, "R2 bank wrap");
        do_direct(2'd2, 16'h8000, 16'h0000, 16'h9001, 8'h40, 1'b0, "R3 indexed Y carry");
        do_direct(2'd1, 16'h1000, 16'hab10, 16'h0000, 8'h01, 1'b1, "R4 idx8 X");
        do_direct(2'd2, 16'hff80, 16'h0000, 16'hc0c0, 8'h02, 1'b1, "R4 idx8 Y carry");
        do_jump(16'h1234, 16'h0010, 8'h5a, 1'b0, 0, 0, 1'b0);
        do_jump(16'hfff0, 16'h000f, 8'h21, 1'b0, 2, 1, 1'b0);
        do_jump(16'h2000, 16'hff05, 8'h03, 1'b1, 1, 3, 1'b0);
        do_jump(16'h4000, 16'h0004, 8'h44, 1'b0, 3, 2, 1'b1);

        for (int n = 0; n < 300; n++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 3));
            if (m == 2'd3)
                do_jump(16'($urandom), 16'($urandom), 8'($urandom), 1'($urandom),
                        $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
            else
                do_direct(m, 16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
                          1'($urandom), m == 2'd0 ? "R1 random" : (m == 2'd1 ? "R2 random" : "R3 random"));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule